// File: doc/BRIEF.md
# DMA Port Device Interface

This block is the device-side logic for an external controller on an 8-bit DMA port. The host runs processor cycles with an active-low chip select, a read/write line (1 = read) and one address line. With the address line at 0, the cycle reaches a mode register. With it at 1, the cycle reaches one of three registers, chosen by a select field held in the mode register.

On the device side, a rising edge on a local data strobe captures one byte into an output latch and raises a data request. The host answers with an active-low acknowledge. While the acknowledge is held, the latched byte is enabled onto the port data bus and the request is withdrawn. The request and interrupt outputs are drive-low enables for open-drain lines: a 1 means pull the line low. The data bus has a separate output-enable for its tri-state driver.

Each delivered byte advances a counter. When the counter reaches a programmed threshold and the interrupt is enabled, the interrupt is raised. Any mode-register access clears the interrupt. The enable bit resets to 0, so the interrupt line is quiet after reset.

Top module: `dma_port_dev`

## Requirements
- R1: After reset, `irq_drive`, `drq_drive` and `bus_oe` are 0 and the mode register reads 0x00.
- R2: A write cycle with `a1`=0 stores all 8 bits of `bus_in` in the mode register, and a read cycle with `a1`=0 returns them. Mode bit 0 is the interrupt enable, bit 1 the capture enable, bits 3:2 the register select, and bits 7:4 are plain storage.
- R3: With `a1`=1, the select field picks the register. Select 0 is the threshold, read/write and CNT_W bits wide, with upper bits reading 0. Select 1 is the delivered-byte count, readable, and any write clears it. Select 2 is the status: bit 0 overrun, bit 1 byte pending, bit 2 interrupt pending; any write clears overrun. Select 3 reads 0x00 and ignores writes.
- R4: When capture is enabled and no byte is pending or being acknowledged, a rising edge on `strobe` latches `dev_data`. `drq_drive` then rises on the third clock edge after the strobe is sampled high.
- R5: While the synchronized `ack_n` is low, `bus_oe` is 1 and `bus_out` carries the latched byte, and a pending request is cleared (`drq_drive` goes to 0).
- R6: A strobe edge that arrives while a byte is pending or `ack_n` is still held leaves the latched byte unchanged and sets the overrun flag. A new byte is accepted only after the acknowledge is released.
- R7: Each release of an acknowledge that took a byte advances the count by one. When the advanced count equals a non-zero threshold, the count returns to 0 and, if the interrupt enable is 1, `irq_drive` becomes 1.
- R8: Any read or write access to the mode register clears a pending interrupt. An `a1`=1 access does not clear it.
- R9: While the interrupt enable is 0, `irq_drive` stays 0 even when the threshold is reached.
- R10: While the capture enable is 0, strobe edges are ignored: `drq_drive` stays 0 and no byte is latched.
- R11: During a host read cycle (`cs_n`=0, `rw`=1) with no acknowledge active, `bus_oe` is 1. With neither a read cycle nor an acknowledge active, `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low |
| rw | input | 1 | Host cycle type, 1 = read |
| a1 | input | 1 | Host address line: 0 = mode register, 1 = selected register |
| bus_in | input | 8 | Data bus value during host write cycles |
| bus_out | output | 8 | Value driven onto the data bus |
| bus_oe | output | 1 | Tri-state enable for `bus_out` |
| ack_n | input | 1 | Host DMA acknowledge, active low, asynchronous |
| strobe | input | 1 | Local data strobe, capture on rising edge, asynchronous |
| dev_data | input | 8 | Local byte to deliver, held stable around the strobe |
| drq_drive | output | 1 | Pull the data-request line low when 1 |
| irq_drive | output | 1 | Pull the interrupt line low when 1 |

## Verification
The bench builds the block with CNT_W=4 and the default two-stage synchronizer. The narrow threshold makes truncation of wide writes visible. It also lets the bench reach the count wrap at a small threshold within a few deliveries, both with the interrupt enabled and with it disabled. Two synchronizer stages fix the strobe-to-request latency at three clock edges, which the bench samples against directly.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_THRESH = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    // Mode register layout, LSB last
    typedef struct packed {
        logic [3:0] spare;
        sel_e       sel;
        logic       cap_en;
        logic       irq_en;
    } mode_t;

    // One decoded host access, valid for a single clock
    typedef struct packed {
        logic              valid;
        logic              is_mode;
        logic              wr;
        logic [BYTE_W-1:0] wdata;
    } hacc_t;

    typedef struct packed {
        logic irq;
        logic pending;
        logic overrun;
    } stat_t;

    function automatic logic [BYTE_W-1:0] stat_byte(stat_t s);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[2:0] = {s.irq, s.pending, s.overrun};
        return b;
    endfunction

endpackage

// File: rtl/dpd_sync.sv
module dpd_sync #(
    parameter int                STAGES    = 2,
    parameter int                WIDTH     = 1,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RESET_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dpd_hostif.sv
module dpd_hostif
    import dpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rw,
    input  logic              a1,
    input  logic [BYTE_W-1:0] bus_in,
    output hacc_t             acc,
    output logic              host_rd
);
    logic cs_n_q;

    always_ff @(posedge clk) begin
        if (rst) cs_n_q <= 1'b1;
        else     cs_n_q <= cs_n;
    end

    // An access is taken once, on the first clock of the select
    always_comb begin
        acc.valid   = !cs_n && cs_n_q;
        acc.is_mode = !a1;
        acc.wr      = !rw;
        acc.wdata   = bus_in;
    end

    assign host_rd = !cs_n && rw;
endmodule

// File: rtl/dpd_regs.sv
module dpd_regs
    import dpd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  hacc_t             acc,
    input  logic              rd_a1,
    input  logic              delivered,
    input  logic              pending,
    input  logic              overrun,
    output mode_t             mode,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    output logic              ovr_clr
);
    mode_t            mode_q;
    logic [CNT_W-1:0] thresh_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic             irq_q;
    logic             mode_touch;
    logic             sel_wr;
    logic             hit;
    logic [BYTE_W-1:0] cnt_byte;
    logic [BYTE_W-1:0] thr_byte;

    assign mode_touch = acc.valid && acc.is_mode;
    assign sel_wr     = acc.valid && !acc.is_mode && acc.wr;
    assign count_inc  = count_q + 1'b1;
    assign hit        = delivered && (thresh_q != '0) && (count_inc == thresh_q);
    assign ovr_clr    = sel_wr && (mode_q.sel == SEL_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            thresh_q <= '0;
            count_q  <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (mode_touch && acc.wr) mode_q <= mode_t'(acc.wdata);
            if (sel_wr && mode_q.sel == SEL_THRESH) thresh_q <= acc.wdata[CNT_W-1:0];
            if (sel_wr && mode_q.sel == SEL_COUNT) count_q <= '0;
            else if (delivered) count_q <= hit ? '0 : count_inc;
            // a mode access wins over a simultaneous threshold hit
            irq_q <= mode_q.irq_en && !mode_touch && (irq_q || hit);
        end
    end

    always_comb begin
        cnt_byte = '0;
        cnt_byte[CNT_W-1:0] = count_q;
        thr_byte = '0;
        thr_byte[CNT_W-1:0] = thresh_q;
    end

    always_comb begin
        if (!rd_a1) begin
            rdata = BYTE_W'(mode_q);
        end else begin
            unique case (mode_q.sel)
                SEL_THRESH: rdata = thr_byte;
                SEL_COUNT:  rdata = cnt_byte;
                SEL_STATUS: rdata = stat_byte('{irq: irq_q, pending: pending, overrun: overrun});
                default:    rdata = '0;
            endcase
        end
    end

    assign mode = mode_q;
    assign irq  = irq_q;
endmodule

// File: rtl/dpd_xfer.sv
module dpd_xfer
    import dpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              ack_n,
    input  logic [BYTE_W-1:0] dev_data,
    input  logic              cap_en,
    input  logic              ovr_clr,
    output logic              pending,
    output logic              overrun,
    output logic              ack_act,
    output logic              delivered,
    output logic [BYTE_W-1:0] latch
);
    logic [1:0]        sync_q;
    logic              stb_s, stb_q, stb_rise;
    logic              ack_prev, taken_q;
    logic              pending_q, overrun_q;
    logic              busy, accept, release_ev;
    logic [BYTE_W-1:0] latch_q;

    dpd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RESET_VAL(2'b01)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({strobe, ack_n}),
        .q   (sync_q)
    );

    assign stb_s      = sync_q[1];
    assign ack_act    = !sync_q[0];
    assign stb_rise   = stb_s && !stb_q;
    assign busy       = pending_q || ack_act;
    assign accept     = stb_rise && cap_en && !busy;
    assign release_ev = ack_prev && !ack_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q     <= 1'b0;
            ack_prev  <= 1'b0;
            taken_q   <= 1'b0;
            pending_q <= 1'b0;
            overrun_q <= 1'b0;
            latch_q   <= '0;
        end else begin
            stb_q    <= stb_s;
            ack_prev <= ack_act;
            if (accept) begin
                latch_q   <= dev_data;
                pending_q <= 1'b1;
            end else if (ack_act && pending_q) begin
                pending_q <= 1'b0;
            end
            if (ack_act && pending_q) taken_q <= 1'b1;
            else if (release_ev)      taken_q <= 1'b0;
            if (stb_rise && cap_en && busy) overrun_q <= 1'b1;
            else if (ovr_clr)               overrun_q <= 1'b0;
        end
    end

    assign pending   = pending_q;
    assign overrun   = overrun_q;
    assign delivered = release_ev && taken_q;
    assign latch     = latch_q;
endmodule

// File: rtl/dma_port_dev.sv
module dma_port_dev
    import dpd_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rw,
    input  logic        a1,
    input  logic [7:0]  bus_in,
    output logic [7:0]  bus_out,
    output logic        bus_oe,
    input  logic        ack_n,
    input  logic        strobe,
    input  logic [7:0]  dev_data,
    output logic        drq_drive,
    output logic        irq_drive
);
    hacc_t             acc;
    logic              host_rd;
    mode_t             mode_q;
    logic [BYTE_W-1:0] rdata;
    logic              irq, ovr_clr;
    logic              pending, overrun, ack_act, delivered;
    logic [BYTE_W-1:0] latch;

    dpd_hostif u_host (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .rw      (rw),
        .a1      (a1),
        .bus_in  (bus_in),
        .acc     (acc),
        .host_rd (host_rd)
    );

    dpd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .rd_a1     (a1),
        .delivered (delivered),
        .pending   (pending),
        .overrun   (overrun),
        .mode      (mode_q),
        .rdata     (rdata),
        .irq       (irq),
        .ovr_clr   (ovr_clr)
    );

    dpd_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .ack_n     (ack_n),
        .dev_data  (dev_data),
        .cap_en    (mode_q.cap_en),
        .ovr_clr   (ovr_clr),
        .pending   (pending),
        .overrun   (overrun),
        .ack_act   (ack_act),
        .delivered (delivered),
        .latch     (latch)
    );

    // acknowledge has priority over a host read on the shared bus
    assign bus_oe    = ack_act || host_rd;
    assign bus_out   = ack_act ? latch : rdata;
    assign drq_drive = pending;
    assign irq_drive = irq;
endmodule

// File: rtl/dpd_chk.sv
module dpd_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq_drive,
    input logic       drq_drive,
    input logic       bus_oe,
    input logic       ack_act,
    input logic       irq_en,
    input logic       cap_en,
    input logic       mode_touch,
    input logic       overrun,
    input logic       ovr_clr,
    input logic [7:0] latch
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq_drive && !drq_drive));

    p_drq_drop_on_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_act && drq_drive) |=> !drq_drive);

    p_oe_on_ack_r5: assert property (@(posedge clk) disable iff (rst)
        ack_act |-> bus_oe);

    p_latch_held_r6: assert property (@(posedge clk) disable iff (rst)
        (drq_drive && !ack_act) |=> $stable(latch));

    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);

    p_mode_clears_irq_r8: assert property (@(posedge clk) disable iff (rst)
        mode_touch |=> !irq_drive);

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> !irq_drive);

    p_drq_needs_cap_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(drq_drive) |-> $past(cap_en));
endmodule

bind dma_port_dev dpd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_drive  (irq_drive),
    .drq_drive  (drq_drive),
    .bus_oe     (bus_oe),
    .ack_act    (ack_act),
    .irq_en     (mode_q.irq_en),
    .cap_en     (mode_q.cap_en),
    .mode_touch (acc.valid && acc.is_mode),
    .overrun    (overrun),
    .ovr_clr    (ovr_clr),
    .latch      (latch)
);

// File: tb/sim_dma_port_dev.sv
module sim_dma_port_dev;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rw = 1'b1, a1 = 1'b0;
    logic [7:0] bus_in = '0, dev_data = '0;
    logic       ack_n = 1'b1, strobe = 1'b0;
    logic [7:0] bus_out;
    logic       bus_oe, drq_drive, irq_drive;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_port_dev #(.CNT_W(4), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .a1(a1), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .ack_n(ack_n), .strobe(strobe),
        .dev_data(dev_data), .drq_drive(drq_drive), .irq_drive(irq_drive)
    );

    typedef struct packed {
        logic       a1;
        logic       rd;
        logic [7:0] d;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'h0C, 8'h00},  // mode sel=3
        '{1'b0, 1'b1, 8'h00, 8'h0C},  // R2 read back
        '{1'b1, 1'b0, 8'h55, 8'h00},  // R3 sel 3 write ignored
        '{1'b1, 1'b1, 8'h00, 8'h00},  // R3 sel 3 reads zero
        '{1'b0, 1'b0, 8'hF0, 8'h00},  // mode sel=0, upper bits set
        '{1'b0, 1'b1, 8'h00, 8'hF0},  // R2 upper storage bits
        '{1'b1, 1'b0, 8'hFF, 8'h00},  // threshold write, wide value
        '{1'b1, 1'b1, 8'h00, 8'h0F},  // R3 threshold truncated to 4 bits
        '{1'b1, 1'b0, 8'h02, 8'h00},  // threshold = 2
        '{1'b1, 1'b1, 8'h00, 8'h02}   // R3 threshold read
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic host(input logic ia1, input logic ird, input logic [7:0] d,
                        output logic [7:0] rd, output logic oe);
        @(negedge clk);
        a1 = ia1; rw = ird; bus_in = d; cs_n = 1'b0;
        @(negedge clk);
        rd = bus_out; oe = bus_oe;
        cs_n = 1'b1; rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        dev_data = d; strobe = 1'b1;
        repeat (4) @(negedge clk);
        strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic take(output logic [7:0] d, output logic oe);
        @(negedge clk);
        ack_n = 1'b0;
        repeat (3) @(negedge clk);
        d = bus_out; oe = bus_oe;
        ack_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, b;
        logic oe;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!irq_drive && !drq_drive && !bus_oe, "R1 outputs quiet",
            {irq_drive, drq_drive, bus_oe}, 0);
        host(1'b0, 1'b1, 8'h00, r, oe);
        chk(r == 8'h00, "R1 mode after reset", r, 8'h00);
        chk(oe == 1'b1, "R11 oe during read", oe, 1);
        chk(bus_oe == 1'b0, "R11 oe idle", bus_oe, 0);

        // register vectors
        for (int i = 0; i < NV; i++) begin
            host(VEC[i].a1, VEC[i].rd, VEC[i].d, r, oe);
            if (VEC[i].rd) chk(r == VEC[i].exp, $sformatf("R2/R3 vector %0d", i), r, VEC[i].exp);
        end

        // R4/R6: enable irq+capture, select status (0x0B)
        host(1'b0, 1'b0, 8'h0B, r, oe);
        push(8'hA5);
        chk(drq_drive == 1'b1, "R4 drq after strobe", drq_drive, 1);
        push(8'h3C);
        host(1'b1, 1'b1, 8'h00, r, oe);
        chk(r == 8'h03, "R6 status overrun+pending", r, 8'h03);
        take(b, oe);
        chk(oe == 1'b1, "R5 oe during ack", oe, 1);
        chk(b == 8'hA5, "R6 first byte kept", b, 8'hA5);
        chk(drq_drive == 1'b0, "R5 drq cleared", drq_drive, 0);
        host(1'b1, 1'b1, 8'h00, r, oe);
        chk(r == 8'h01, "R3 status after ack", r, 8'h01);
        host(1'b1, 1'b0, 8'h00, r, oe);
        host(1'b1, 1'b1, 8'h00, r, oe);
        chk(r == 8'h00, "R3 status write clears overrun", r, 8'h00);

        // R7: count and threshold
        host(1'b0, 1'b0, 8'h07, r, oe);
        host(1'b1, 1'b1, 8'h00, r, oe);
        chk(r == 8'h01, "R7 count one", r, 8'h01);
        chk(irq_drive == 1'b0, "R7 no irq below threshold", irq_drive, 0);
        push(8'hB7);
        take(b, oe);
        chk(b == 8'hB7, "R5 second byte", b, 8'hB7);
        chk(irq_drive == 1'b1, "R7 irq at threshold", irq_drive, 1);
        host(1'b1, 1'b1, 8'h00, r, oe);
        chk(r == 8'h00, "R7 count wrapped", r, 8'h00);
        chk(irq_drive == 1'b1, "R8 a1=1 access keeps irq", irq_drive, 1);
        host(1'b0, 1'b1, 8'h00, r, oe);
        chk(irq_drive == 1'b0, "R8 mode read clears irq", irq_drive, 0);

        // R3 count write clears
        push(8'h21);
        take(b, oe);
        host(1'b1, 1'b0, 8'h00, r, oe);
        host(1'b1, 1'b1, 8'h00, r, oe);
        chk(r == 8'h00, "R3 count write clears", r, 8'h00);

        // R9: irq disabled, reach threshold
        host(1'b0, 1'b0, 8'h06, r, oe);
        push(8'hC1);
        take(b, oe);
        push(8'hC2);
        take(b, oe);
        chk(b == 8'hC2, "R4 byte after release", b, 8'hC2);
        chk(irq_drive == 1'b0, "R9 irq suppressed", irq_drive, 0);
        host(1'b1, 1'b1, 8'h00, r, oe);
        chk(r == 8'h00, "R9 count wraps silently", r, 8'h00);

        // R10: capture disabled
        host(1'b0, 1'b0, 8'h04, r, oe);
        push(8'h11);
        chk(drq_drive == 1'b0, "R10 strobe ignored", drq_drive, 0);
        take(b, oe);
        chk(b == 8'hC2, "R10 latch unchanged", b, 8'hC2);
        host(1'b1, 1'b1, 8'h00, r, oe);
        chk(r == 8'h00, "R10 nothing delivered", r, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule